// File: doc/BRIEF.md
# GPIO Interrupt Capture Unit

This block turns thirty-two general-purpose input pins into interrupt requests. The pins are grouped into two banks of sixteen, and each bank has its own set of 16-bit control and status registers on a small synchronous register bus. For every pin, software picks edge or level sensing, which polarity counts as active, and whether a detected request is held until software acknowledges it or simply mirrors the qualified input. A per-pin enable decides whether a pending request reaches the single combined interrupt output.

Every pin passes through a two-flop synchronizer before detection. Edge sensing compares the synchronized sample with the one taken a cycle earlier. Pending status is always visible, whether or not the pin is enabled. Software acknowledges held requests by writing ones to the status register. The interrupt output is a registered OR of pending-and-enabled bits over both banks.

Top module: `gpio_irq_capture`

## Requirements
- R1: While reset is asserted and on leaving it, every control register (enable, mode, polarity, hold) reads zero. The interrupt output is low. Status reads zero while reset is held.
- R2: Bank 0 holds pins 0 to 15 and bank 1 holds pins 16 to 31. The pin at offset i inside a bank sits at register bit 15-i, so offset 0 is bit 15.
- R3: A level-mode pin (mode bit 0) is active when its synchronized input equals its polarity bit. Polarity 1 means high and polarity 0 means low. The status bit of a pass-through pin (hold bit 0) follows this within three clock edges of an input change.
- R4: An edge-mode pin (mode bit 1) detects only the edge its polarity bit selects: rising for 1, falling for 0. The opposite edge raises no request.
- R5: In hold mode (hold bit 1) a detected request stays set in status until software clears it, even after the input goes inactive.
- R6: A write to the status register clears exactly the held bits written as 1. Bits written as 0 keep their value.
- R7: For a pass-through pin, writing 1 to its status bit has no lasting effect. Status stays set while the input remains active.
- R8: When a detection and a clear of the same pin fall in the same cycle, the detection wins and the request stays pending.
- R9: Status bits show pending requests whether or not the pin is enabled.
- R10: The interrupt output equals, one cycle later, the OR over both banks of status AND enable.
- R11: Register address = {bank, select}, where the bank is address bit 3 and the select is bits 2:0. The selects are 0 status (write one to clear), 1 enable, 2 mode, 3 polarity and 4 hold. Selects 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous interrupt pins, bit p is pin p |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {bank, select} |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
A wrong detection or hold state shows up as a status readback that disagrees with the model. This is visible four clock edges after the pin moves: two synchronizer stages, the status flop and one more edge of margin. A bad enable or OR term appears on irq_out one cycle after status settles, and the bench checks that latency exactly. A clear that reaches the wrong bit, or is lost to a same-cycle detection, shows on the very next readback after the write. Random configurations, toggles and clears are scored against a per-pin model that maps bits in its own way.

// File: rtl/gic_pkg.sv
package gic_pkg;

  typedef enum logic [2:0] {
    RSEL_STATUS = 3'd0,
    RSEL_ENABLE = 3'd1,
    RSEL_MODE   = 3'd2,
    RSEL_POL    = 3'd3,
    RSEL_HOLD   = 3'd4
  } reg_sel_e;

  // Qualified detection for one pin: level or edge, chosen polarity.
  function automatic logic pin_detect(input logic cur, input logic prv,
                                      input logic edge_mode, input logic act_high);
    logic lvl;
    logic edg;
    lvl = act_high ? cur : ~cur;
    edg = act_high ? (cur & ~prv) : (~cur & prv);
    return edge_mode ? edg : lvl;
  endfunction

  // Next status of one pin: held requests survive unless cleared, set wins.
  function automatic logic status_next(input logic cur_st, input logic det,
                                       input logic hold, input logic clr);
    return hold ? (det | (cur_st & ~clr)) : det;
  endfunction

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/gic_bank.sv
module gic_bank
  import gic_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,   // offset order: index i is pin offset i
  input  logic [W-1:0] mode_q,     // register bit order from here on
  input  logic [W-1:0] pol_q,
  input  logic [W-1:0] hold_q,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status_q,
  output logic [W-1:0] detect_w
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pin_bits;   // synchronized pins in register bit order
  logic [W-1:0] status_d;

  always_comb begin
    for (int i = 0; i < W; i++) pin_bits[W-1-i] = pin_sync[i];
  end

  always_comb begin
    for (int b = 0; b < W; b++) begin
      detect_w[b] = pin_detect(pin_bits[b], prev_q[b], mode_q[b], pol_q[b]);
      status_d[b] = status_next(status_q[b], detect_w[b], hold_q[b], clr_mask[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= pin_bits;
      status_q <= status_d;
    end
  end

  // R5: a held, uncleared request survives the edge
  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & hold_q & ~clr_mask)) ==
              $past(status_q & hold_q & ~clr_mask)));

  // R6: a cleared held bit with no new detection drops
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_mask & hold_q & ~detect_w)) == '0));

  // R8: any detection is pending next cycle, clear or not
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_w != '0) |=> ((status_q & $past(detect_w)) == $past(detect_w)));

  // R7: pass-through bits mirror the previous cycle's detection
  a_r7_through_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(hold_q)) == ($past(detect_w) & ~$past(hold_q))));

  // R4: an edge-mode detection needs a change in the synchronized input
  a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((detect_w & mode_q & ~(pin_bits ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_irq_capture.sv
module gpio_irq_capture
  import gic_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS   = NUM_BANKS * BANK_W,
  localparam int BANK_BITS  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W     = BANK_BITS + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [BANK_W-1:0]   reg_wdata,
  output logic [BANK_W-1:0]   reg_rdata,
  output logic                irq_out
);
  logic [NUM_PINS-1:0]                pin_sync;
  logic [NUM_BANKS-1:0][BANK_W-1:0]   en_q, mode_q, pol_q, hold_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0]   status_w, detect_w, clr_w, masked_w;
  logic [NUM_BANKS-1:0]               wr_bank;
  logic [BANK_BITS-1:0]               acc_bank;
  logic [2:0]                         acc_sel;
  logic                               bank_ok;
  logic                               irq_d;
  logic                               irq_q;

  assign acc_bank = reg_addr[ADDR_W-1:3];
  assign acc_sel  = reg_addr[2:0];
  assign bank_ok  = (int'(acc_bank) < NUM_BANKS);

  gic_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .d_out (pin_sync)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    assign wr_bank[k]  = reg_we && bank_ok && (acc_bank == BANK_BITS'(k));
    assign clr_w[k]    = (wr_bank[k] && acc_sel == RSEL_STATUS) ? reg_wdata : '0;
    assign masked_w[k] = status_w[k] & en_q[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[k]   <= '0;
        mode_q[k] <= '0;
        pol_q[k]  <= '0;
        hold_q[k] <= '0;
      end else if (wr_bank[k]) begin
        case (acc_sel)
          RSEL_ENABLE: en_q[k]   <= reg_wdata;
          RSEL_MODE:   mode_q[k] <= reg_wdata;
          RSEL_POL:    pol_q[k]  <= reg_wdata;
          RSEL_HOLD:   hold_q[k] <= reg_wdata;
          default: ;
        endcase
      end
    end

    gic_bank #(.W(BANK_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync[k*BANK_W +: BANK_W]),
      .mode_q   (mode_q[k]),
      .pol_q    (pol_q[k]),
      .hold_q   (hold_q[k]),
      .clr_mask (clr_w[k]),
      .status_q (status_w[k]),
      .detect_w (detect_w[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (bank_ok && acc_bank == BANK_BITS'(k)) begin
        case (acc_sel)
          RSEL_STATUS: reg_rdata = status_w[k];
          RSEL_ENABLE: reg_rdata = en_q[k];
          RSEL_MODE:   reg_rdata = mode_q[k];
          RSEL_POL:    reg_rdata = pol_q[k];
          RSEL_HOLD:   reg_rdata = hold_q[k];
          default:     reg_rdata = '0;
        endcase
      end
    end
  end

  assign irq_d = |masked_w;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_out = irq_q;

  // R10: output is last cycle's pending-and-enabled summary
  a_r10_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(status_w & en_q))));

  // R11: writes to unused selects leave all control state alone
  a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && acc_sel > 3'd4) |=> ($stable(en_q) && $stable(mode_q) &&
                                    $stable(pol_q) && $stable(hold_q)));

  // R9: enables never alter status on their own
  a_r9_status_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && $stable(pin_sync)) |=> ($past(status_w & hold_q) & ~status_w) == '0);
endmodule

// File: tb/gpio_irq_capture_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  bit m_mode[32], m_pol[32], m_hold[32], m_en[32], m_st[32], m_pin[32];

  always #2.5 clk = ~clk;

  gpio_irq_capture dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // bench-side packing: pin offset i of bank bk lands at bit 15-i
  function automatic logic [15:0] pack(input int bk, input int sel);
    logic [15:0] v = '0;
    for (int i = 0; i < 16; i++) begin
      int p = bk * 16 + i;
      bit b;
      case (sel)
        0: b = m_st[p];
        1: b = m_en[p];
        2: b = m_mode[p];
        3: b = m_pol[p];
        default: b = m_hold[p];
      endcase
      v[15 - i] = b;
    end
    return v;
  endfunction

  function automatic bit exp_irq();
    bit r = 0;
    for (int p = 0; p < 32; p++) r |= m_st[p] & m_en[p];
    return r;
  endfunction

  function automatic void model_settle();
    for (int p = 0; p < 32; p++) begin
      bit act = m_mode[p] ? 1'b0 : (m_pin[p] == m_pol[p]);
      if (m_hold[p]) m_st[p] = m_st[p] | act;
      else           m_st[p] = act;
    end
  endfunction

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input int bk, input int sel, input logic [15:0] d);
    wr(4'(bk * 8 + sel), d);
    for (int i = 0; i < 16; i++) begin
      int p = bk * 16 + i;
      bit b = d[15 - i];
      case (sel)
        0: if (b && m_hold[p]) m_st[p] = 1'b0;
        1: m_en[p] = b;
        2: m_mode[p] = b;
        3: m_pol[p] = b;
        4: m_hold[p] = b;
        default: ;
      endcase
    end
    wait_cyc(6);
    model_settle();
  endtask

  task automatic apply(input logic [31:0] np);
    for (int p = 0; p < 32; p++) begin
      bit rise = !m_pin[p] && np[p];
      bit fall = m_pin[p] && !np[p];
      bit ev = m_mode[p] && (m_pol[p] ? rise : fall);
      if (ev && m_hold[p]) m_st[p] = 1'b1;
      m_pin[p] = np[p];
    end
    @(negedge clk);
    pin_in = np;
    wait_cyc(6);
    model_settle();
  endtask

  task automatic check_all(input string tag);
    logic [15:0] v;
    for (int bk = 0; bk < 2; bk++) begin
      for (int s = 0; s < 5; s++) begin
        rd(4'(bk * 8 + s), v);
        chk($sformatf("%s bank%0d sel%0d", tag, bk, s), {16'h0, v}, {16'h0, pack(bk, s)});
      end
    end
    chk({tag, " irq R10"}, {31'h0, irq_out}, {31'h0, exp_irq()});
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    void'($urandom(32'h5eed_0421));
    // R1: reset state
    wait_cyc(3);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reset addr%0d", a), {16'h0, v}, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq_out}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(6);
    model_settle();
    check_all("R1/R3 post-reset active-low default");

    // R2/R3: pin 16 level high pass-through maps to bank1 bit 15
    cfg(1, 3, 16'h8000);
    apply(32'h0001_0000);
    check_all("R2/R3 pin16 high level");
    rd(4'h8, v);
    chk("R2 pin16 at bit15", {31'h0, v[15]}, 32'h1);

    // R4/R5: pins 1,2 rising edge held
    cfg(0, 3, 16'h6000);
    cfg(0, 2, 16'h6000);
    cfg(0, 4, 16'h6000);
    apply(32'h0001_0006);
    check_all("R4/R5 rising edges latched");
    apply(32'h0001_0000);
    check_all("R5 held after input drops");
    // R6: clear pin1 only
    cfg(0, 0, 16'h4000);
    rd(4'h0, v);
    chk("R6 pin1 cleared", {31'h0, v[14]}, 32'h0);
    chk("R6 pin2 kept", {31'h0, v[13]}, 32'h1);
    // R4: falling edge on rising-configured pin raises nothing
    apply(32'h0001_0002);
    cfg(0, 0, 16'h6000);
    apply(32'h0001_0000);
    rd(4'h0, v);
    chk("R4 falling ignored", {30'h0, v[14:13]}, 32'h0);
    cfg(0, 3, 16'h0000);
    apply(32'h0001_0002);
    rd(4'h0, v);
    chk("R4 falling-mode rise ignored", {31'h0, v[14]}, 32'h0);
    apply(32'h0001_0000);
    rd(4'h0, v);
    chk("R4 falling detected", {31'h0, v[14]}, 32'h1);
    check_all("R4 model");

    // R8: held level pin 5 active, clear loses to detection
    cfg(0, 2, 16'h0000);
    cfg(0, 3, 16'h0400);
    cfg(0, 4, 16'h0400);
    apply(32'h0001_0020);
    wr(4'h0, 16'h0400);
    rd(4'h0, v);
    chk("R8 set beats clear", {31'h0, v[10]}, 32'h1);
    // R9/R10: enable pin5 -> irq one cycle later
    cfg(0, 1, 16'h0000);
    check_all("R9 pending while disabled");
    wr(4'h1, 16'h0400);
    m_en[5] = 1'b1;
    chk("R10 irq not yet", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R10 irq after one cycle", {31'h0, irq_out}, 32'h1);

    // R7: pass-through pin 16 clear has no lasting effect
    wr(4'h8, 16'h8000);
    rd(4'h8, v);
    chk("R7 through clear ignored", {31'h0, v[15]}, 32'h1);
    wait_cyc(4);
    model_settle();

    // R11: unmapped selects
    rd(4'h5, v);
    chk("R11 sel5 reads zero", {16'h0, v}, 32'h0);
    rd(4'hF, v);
    chk("R11 sel7 reads zero", {16'h0, v}, 32'h0);
    wr(4'h6, 16'hFFFF);
    wr(4'hF, 16'hFFFF);
    wait_cyc(2);
    check_all("R11 unmapped write ignored");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int bk = int'($urandom_range(0, 1));
      int sel = int'($urandom_range(1, 4));
      cfg(bk, sel, 16'($urandom));
      apply(m_pin_vec() ^ ($urandom & $urandom));
      check_all($sformatf("rand%0d R3/R4/R5/R9", it));
      if ($urandom_range(0, 2) == 0) begin
        cfg(int'($urandom_range(0, 1)), 0, 16'($urandom));
        check_all($sformatf("rand%0d R6/R7 clear", it));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] m_pin_vec();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[p] = m_pin[p];
    return r;
  endfunction
endmodule